// File: doc/BRIEF.md
# Audio Sample Hold and Mute Controller

This block sits between a stereo receiver and the DAC data path. Once per stereo frame, marked by a one-cycle frame strobe, it decides whether the frame carries usable audio. A frame is rejected when a hold request was seen at any cycle of that frame period. A hold request is either the external hold input or one of three receiver error flags: parity, biphase or validity. Each error flag has its own mask bit. For a rejected frame the block ignores the incoming left/right words and repeats the last accepted pair. For a good frame it latches the new pair.

A saturating counter tracks how many consecutive frames have been held. Two control inputs pick the mute policy. The first disables automatic muting. The second chooses how mute is left when the hold clears: either the block unmutes on the first good frame, or mute stays latched until software issues an unmute write. While muted, both outputs drive zero. The held pair is kept, so after unmuting the outputs show the last accepted sample.

Top module: `audio_hold_mute`

## Requirements
- R1: After reset, left_o, right_o, hold_o and mute_o are all 0.
- R2: On a frame strobe with no hold request in that frame period, the left_i/right_i pair present at the strobe appears on left_o/right_o in the next cycle, and hold_o is 0.
- R3: A hold_i pulse in any cycle from the cycle after one strobe up to and including the next strobe makes that frame a held frame: hold_o is 1 after the strobe.
- R4: par_err_i, bip_err_i and val_err_i each request a hold when present at the strobe, unless its mask bit (mask_par_i, mask_bip_i, mask_val_i) is 1, in which case it has no effect.
- R5: In a held frame, left_i/right_i are ignored and left_o/right_o repeat the last accepted pair.
- R6: With mute_auto_off_i = 0, mute_o rises after the 16th consecutive held frame strobe and not before. While mute_o is 1, left_o and right_o are 0.
- R7: With mute_auto_off_i = 1, mute_o never rises however long the hold lasts, and the latched pair keeps being output.
- R8: With unmute_sw_i = 0, a muted output unmutes at the first strobe without a hold request, and shows that frame's new pair.
- R9: With unmute_sw_i = 1, mute_o stays 1 after the hold clears until an unmute_wr_i pulse while hold_o is 0. mute_o is 0 in the cycle after that pulse.
- R10: An unmute_wr_i pulse while hold_o is 1 is ignored. This includes a pulse in the same cycle as the strobe that ends the hold.
- R11: The held-frame count restarts at zero whenever a frame is accepted, so two holds of 10 frames separated by one good frame never mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle stereo frame strobe |
| hold_i | input | 1 | External hold request |
| par_err_i | input | 1 | Receiver parity error |
| bip_err_i | input | 1 | Receiver biphase error |
| val_err_i | input | 1 | Receiver validity error |
| mask_par_i | input | 1 | 1 masks parity errors |
| mask_bip_i | input | 1 | 1 masks biphase errors |
| mask_val_i | input | 1 | 1 masks validity errors |
| mute_auto_off_i | input | 1 | 1 disables mute after a long hold |
| unmute_sw_i | input | 1 | 1 requires a software unmute write after a hold |
| unmute_wr_i | input | 1 | Software unmute write pulse |
| left_i | input | WIDTH | Incoming left sample |
| right_i | input | WIDTH | Incoming right sample |
| left_o | output | WIDTH | Left sample to the DAC |
| right_o | output | WIDTH | Right sample to the DAC |
| hold_o | output | 1 | Current frame is held |
| mute_o | output | 1 | Outputs are muted |

## Verification
Two events can meet in one cycle: the frame strobe that ends a hold, and a software unmute write. The bench drives the write in exactly the strobe cycle of the first good frame after a latched mute. hold_o is still 1 in that cycle, so the write must be lost. The scoreboard then expects mute_o to stay 1 and the outputs to stay zero on that frame. A later write, made while hold_o is 0, must clear mute in the next cycle.

// File: rtl/audio_hold_pkg.sv
package audio_hold_pkg;
  typedef struct packed {
    logic val;
    logic bip;
    logic par;
  } rx_err_t;

  function automatic logic err_req(rx_err_t err, rx_err_t mask);
    return |(err & ~mask);
  endfunction
endpackage

// File: rtl/hold_req_detect.sv
module hold_req_detect
  import audio_hold_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    frame_i,
  input  logic    hold_i,
  input  rx_err_t err_i,
  input  rx_err_t mask_i,
  output logic    req_o,
  output logic    hold_o
);
  logic pend_q;
  logic now_req;

  assign now_req = hold_i | err_req(err_i, mask_i);
  assign req_o   = pend_q | now_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_o <= 1'b0;
    end else if (frame_i) begin
      pend_q <= 1'b0;
      hold_o <= req_o;
    end else begin
      pend_q <= pend_q | hold_i;
    end
  end
endmodule

// File: rtl/hold_span_counter.sv
module hold_span_counter #(
  parameter int unsigned MUTE_AFTER = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic req_i,
  output logic over_o
);
  localparam int unsigned CNT_MAX = MUTE_AFTER + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt_q;

  // the frame being counted now pushes the run past the limit
  assign over_o = frame_i & req_i & (cnt_q >= CNT_W'(MUTE_AFTER));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (frame_i) begin
      if (!req_i)                         cnt_q <= '0;
      else if (cnt_q < CNT_W'(CNT_MAX))   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mute_seq.sv
module mute_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic req_i,
  input  logic hold_i,
  input  logic over_i,
  input  logic auto_off_i,
  input  logic sw_unmute_i,
  input  logic unmute_wr_i,
  output logic mute_o
);
  logic set_mute, clr_auto, clr_sw;

  assign set_mute = over_i & ~auto_off_i;
  assign clr_auto = frame_i & ~req_i & ~sw_unmute_i;
  assign clr_sw   = unmute_wr_i & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  mute_o <= 1'b0;
    else if (set_mute)            mute_o <= 1'b1;
    else if (clr_auto || clr_sw)  mute_o <= 1'b0;
  end
endmodule

// File: rtl/sample_hold.sv
module sample_hold #(
  parameter int unsigned WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             mute_i,
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  output logic [WIDTH-1:0] left_o,
  output logic [WIDTH-1:0] right_o
);
  logic [WIDTH-1:0] smp_q [2];
  logic [WIDTH-1:0] smp_d [2];

  assign smp_d[0] = left_i;
  assign smp_d[1] = right_i;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     smp_q[ch] <= '0;
      else if (load_i) smp_q[ch] <= smp_d[ch];
    end
  end

  assign left_o  = mute_i ? '0 : smp_q[0];
  assign right_o = mute_i ? '0 : smp_q[1];
endmodule

// File: rtl/audio_hold_mute.sv
module audio_hold_mute
  import audio_hold_pkg::*;
#(
  parameter int unsigned WIDTH      = 24,
  parameter int unsigned MUTE_AFTER = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             hold_i,
  input  logic             par_err_i,
  input  logic             bip_err_i,
  input  logic             val_err_i,
  input  logic             mask_par_i,
  input  logic             mask_bip_i,
  input  logic             mask_val_i,
  input  logic             mute_auto_off_i,
  input  logic             unmute_sw_i,
  input  logic             unmute_wr_i,
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  output logic [WIDTH-1:0] left_o,
  output logic [WIDTH-1:0] right_o,
  output logic             hold_o,
  output logic             mute_o
);
  rx_err_t err, mask;
  logic    req, over;

  assign err  = '{val: val_err_i,  bip: bip_err_i,  par: par_err_i};
  assign mask = '{val: mask_val_i, bip: mask_bip_i, par: mask_par_i};

  hold_req_detect u_req (
    .clk_i, .rst_ni, .frame_i, .hold_i,
    .err_i(err), .mask_i(mask), .req_o(req), .hold_o(hold_o)
  );

  hold_span_counter #(.MUTE_AFTER(MUTE_AFTER)) u_cnt (
    .clk_i, .rst_ni, .frame_i, .req_i(req), .over_o(over)
  );

  mute_seq u_mute (
    .clk_i, .rst_ni, .frame_i, .req_i(req), .hold_i(hold_o), .over_i(over),
    .auto_off_i(mute_auto_off_i), .sw_unmute_i(unmute_sw_i),
    .unmute_wr_i, .mute_o(mute_o)
  );

  sample_hold #(.WIDTH(WIDTH)) u_smp (
    .clk_i, .rst_ni, .load_i(frame_i & ~req), .mute_i(mute_o),
    .left_i, .right_i, .left_o, .right_o
  );
endmodule

// File: rtl/audio_hold_mute_chk.sv
module audio_hold_mute_chk #(
  parameter int unsigned WIDTH = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_i,
  input logic             mute_auto_off_i,
  input logic             unmute_sw_i,
  input logic             unmute_wr_i,
  input logic [WIDTH-1:0] left_o,
  input logic [WIDTH-1:0] right_o,
  input logic             hold_o,
  input logic             mute_o
);
  a_r6_mute_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o |-> (left_o == '0 && right_o == '0));

  a_r6_mute_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> hold_o && $past(hold_o) && $past(frame_i));

  a_r7_no_auto_mute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mute_o && mute_auto_off_i) |=> !mute_o);

  a_r5_held_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(hold_o) && !mute_o && !$past(mute_o))
      |-> ($stable(left_o) && $stable(right_o)));

  a_r9_sw_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && unmute_sw_i && !unmute_wr_i) |=> mute_o);

  a_r10_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mute_o && hold_o && unmute_sw_i) |=> mute_o);
endmodule

bind audio_hold_mute audio_hold_mute_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i, .rst_ni, .frame_i, .mute_auto_off_i, .unmute_sw_i, .unmute_wr_i,
  .left_o, .right_o, .hold_o, .mute_o
);

// File: tb/audio_hold_mute_tb.sv
module audio_hold_mute_tb;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_i = 0, hold_i = 0, par = 0, bip = 0, val = 0;
  logic mpar = 0, mbip = 0, mval = 0, moff = 0, swu = 0, wr = 0;
  logic [W-1:0] li = '0, ri = '0;
  logic [W-1:0] lo, ro;
  logic hold_o, mute_o;

  int n_tests = 0, n_fail = 0;

  // reference state
  int m_cnt = 0;
  logic m_hold = 0, m_mute = 0;
  logic [W-1:0] m_l = '0, m_r = '0;

  logic [2*W+1:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;  // 250 MHz

  audio_hold_mute #(.WIDTH(W), .MUTE_AFTER(15)) u_dut (
    .clk_i(clk), .rst_ni, .frame_i, .hold_i,
    .par_err_i(par), .bip_err_i(bip), .val_err_i(val),
    .mask_par_i(mpar), .mask_bip_i(mbip), .mask_val_i(mval),
    .mute_auto_off_i(moff), .unmute_sw_i(swu), .unmute_wr_i(wr),
    .left_i(li), .right_i(ri), .left_o(lo), .right_o(ro),
    .hold_o, .mute_o
  );

  task automatic check(string tag, logic [2*W+1:0] act, logic [2*W+1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act l=%h r=%h h=%b m=%b exp l=%h r=%h h=%b m=%b", tag,
               act[2*W+1:W+2], act[W+1:2], act[1], act[0],
               exp[2*W+1:W+2], exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  // monitor: after each strobe, compare at the following negedge
  initial forever begin
    @(posedge clk);
    if (rst_ni && frame_i) begin
      @(negedge clk);
      if (exp_q.size() > 0)
        check(tag_q.pop_front(), {lo, ro, hold_o, mute_o}, exp_q.pop_front());
    end
  end

  // driver: one frame period; pulse = hold_i for one mid-frame cycle,
  // lvl = hold_i level during the strobe, wr_s = unmute write on the strobe
  task automatic frame(logic [W-1:0] l, logic [W-1:0] r, logic pulse, logic lvl,
                       logic wr_s, string tag);
    logic req;
    @(negedge clk);
    hold_i = pulse;
    @(negedge clk);
    hold_i = 1'b0;
    @(negedge clk);
    hold_i = lvl; li = l; ri = r; frame_i = 1'b1; wr = wr_s;
    req = pulse | lvl | (par & ~mpar) | (bip & ~mbip) | (val & ~mval);
    if (wr_s && !m_hold) m_mute = 1'b0;
    if (req) begin
      if (m_cnt < 16) m_cnt++;
      if (!moff && m_cnt >= 16) m_mute = 1'b1;
      m_hold = 1'b1;
    end else begin
      m_cnt = 0; m_hold = 1'b0; m_l = l; m_r = r;
      if (!swu) m_mute = 1'b0;
    end
    exp_q.push_back({m_mute ? '0 : m_l, m_mute ? '0 : m_r, m_hold, m_mute});
    tag_q.push_back(tag);
    @(negedge clk);
    frame_i = 1'b0; hold_i = 1'b0; wr = 1'b0;
  endtask

  task automatic sw_write(string tag);
    @(negedge clk);
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (!m_hold) m_mute = 1'b0;
    check(tag, {lo, ro, hold_o, mute_o},
          {m_mute ? '0 : m_l, m_mute ? '0 : m_r, m_hold, m_mute});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act running exp finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {lo, ro, hold_o, mute_o}, '0);
    rst_ni = 1'b1;
    // R2 plain frames
    frame(24'h111111, 24'h222222, 0, 0, 0, "R2 pass 1");
    frame(24'hABCDEF, 24'h123456, 0, 0, 0, "R2 pass 2");
    frame(24'h800001, 24'h7FFFFE, 0, 0, 0, "R2 pass 3");
    // R3 hold mid-frame and on the strobe
    frame(24'h333333, 24'h444444, 1, 0, 0, "R3 mid pulse");
    frame(24'h555555, 24'h666666, 0, 0, 0, "R2 after hold");
    frame(24'h777777, 24'h888888, 0, 1, 0, "R3 strobe level");
    frame(24'h999999, 24'hAAAAAA, 0, 0, 0, "R2 after hold 2");
    // R4 errors, unmasked then masked
    par = 1; frame(24'h010101, 24'h020202, 0, 0, 0, "R4 parity");
    mpar = 1; frame(24'h030303, 24'h040404, 0, 0, 0, "R4 parity masked");
    par = 0; mpar = 0;
    bip = 1; frame(24'h050505, 24'h060606, 0, 0, 0, "R4 biphase");
    mbip = 1; frame(24'h070707, 24'h080808, 0, 0, 0, "R4 biphase masked");
    bip = 0; mbip = 0;
    val = 1; frame(24'h090909, 24'h0A0A0A, 0, 0, 0, "R4 validity");
    mval = 1; frame(24'h0B0B0B, 24'h0C0C0C, 0, 0, 0, "R4 validity masked");
    val = 0; mval = 0;
    // R5/R6 long hold with auto mute
    for (int i = 0; i < 17; i++)
      frame(24'h100000 + 24'(i), 24'h200000 + 24'(i), 0, 1, 0,
            i < 15 ? "R5 held frame" : "R6 auto mute");
    frame(24'h5A5A5A, 24'hA5A5A5, 0, 0, 0, "R8 auto unmute");
    // R7 auto mute disabled
    moff = 1;
    for (int i = 0; i < 20; i++)
      frame(24'h300000 + 24'(i), 24'h400000, 0, 1, 0, "R7 no mute");
    frame(24'h121212, 24'h343434, 0, 0, 0, "R7 release");
    moff = 0;
    // R11 count restarts
    for (int i = 0; i < 10; i++) frame(24'h600000, 24'h600001, 0, 1, 0, "R11 run a");
    frame(24'h565656, 24'h787878, 0, 0, 0, "R11 gap");
    for (int i = 0; i < 10; i++) frame(24'h610000, 24'h610001, 0, 1, 0, "R11 run b");
    frame(24'h9A9A9A, 24'hBCBCBC, 0, 0, 0, "R11 end");
    // R9/R10 software unmute
    swu = 1;
    for (int i = 0; i < 17; i++) frame(24'h700000, 24'h700001, 0, 1, 0, "R9 held");
    sw_write("R10 write during hold");
    frame(24'hDEAD01, 24'hBEEF01, 0, 0, 1, "R10 write on ending strobe");
    frame(24'hDEAD02, 24'hBEEF02, 0, 0, 0, "R9 stays muted");
    sw_write("R9 write releases");
    frame(24'hDEAD03, 24'hBEEF03, 0, 0, 0, "R9 after release");
    swu = 0;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule